// File: doc/BRIEF.md
# Write-Through Read-Allocate L1 Data Cache

This block is the first-level data cache of a single core. It sits between the core's load/store port and a shared second-level cache, which it reaches through a request channel and a line-fill return channel. Loads that find their line answer from local storage one cycle later. Loads that miss fetch the whole line from the second level and install it. Every store is passed on to the second level. A store updates the local copy only when the line is already present; a store that misses never brings a line in.

A separate invalidate input lets the shared side remove a line after another core has written it. An invalidate may arrive while this cache is waiting for a fill of the same line. In that case the returned data still goes to the core, but the line is not installed. Only one load miss can be outstanding at a time, and the core's port stalls until the fill returns. Tag, valid and data storage are plain register arrays, and each set picks its victim with a round-robin pointer.

Top module: `l1d_wt_cache`

## Requirements
- R1: Default geometry is 8 KB capacity, 16-byte lines and 4 ways. Address bits [3:0] are the byte offset, with [3:2] selecting the 32-bit word. Bits [10:4] are the set index and bits [31:11] the tag. On the fill bus, word k of a line occupies bits [32k+31:32k].
- R2: A load that hits makes no second-level request. It raises `rsp_valid` in the cycle after acceptance, with the addressed word on `rsp_rdata`.
- R3: A load that misses raises `l2_req_valid` with `l2_req_write`=0 and a line-aligned address in its acceptance cycle. In the cycle after `l2_fill_valid`, the cache returns the addressed word of the fill data.
- R4: A completed miss fill installs the line, so a later load to that line hits.
- R5: In its acceptance cycle, every accepted store drives `l2_req_valid`=1 and `l2_req_write`=1, together with its word-aligned address, data and byte enables. A store produces no `rsp_valid`.
- R6: A store that hits merges its enabled bytes into the cached word, and later load hits return the merged value.
- R7: A store that misses does not allocate, so a later load to that line misses.
- R8: Each set has a round-robin victim pointer that is 0 after reset and advances on every install. Loading WAYS+1 distinct lines into one set evicts the oldest of them.
- R9: An invalidate whose address matches a valid line clears it, so the next load to that line misses.
- R10: An invalidate that matches a line with a fill outstanding, in any cycle up to and including the fill cycle, lets the data reach the core but leaves the line uninstalled.
- R11: After reset, `rsp_valid` and `l2_req_valid` are low. While a miss is outstanding, `req_ready` stays low.
- R12: `req_ready` is low whenever `l2_req_ready` is low, and no request is taken in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Cache can take the request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 32 | Load data |
| l2_req_valid | output | 1 | Second-level request present |
| l2_req_ready | input | 1 | Second level accepts a request |
| l2_req_write | output | 1 | 1 = write-through store, 0 = line read |
| l2_req_addr | output | ADDR_W | Request address (word- or line-aligned) |
| l2_req_wdata | output | 32 | Store data |
| l2_req_be | output | 4 | Store byte enables |
| l2_fill_valid | input | 1 | Fill line returned |
| l2_fill_data | input | LINE_BYTES*8 | Fill line |
| inv_valid | input | 1 | Invalidate request |
| inv_addr | input | ADDR_W | Address inside the line to invalidate |

## Verification
The bench builds the cache with ADDR_W=16, CAP_BYTES=256, LINE_BYTES=16 and WAYS=2, which gives eight sets of two ways. Its random addresses span 1 KB, so each set sees eight competing lines. Round-robin evictions, store misses on absent lines and invalidates of resident lines therefore occur often. Remote writes are timed both one cycle before the fill and in the fill cycle itself, which reaches the race between an invalidate and an outstanding miss.

// File: rtl/l1d_pkg.sv
package l1d_pkg;
    typedef enum logic [0:0] {
        L1D_IDLE = 1'b0,
        L1D_FILL = 1'b1
    } l1d_state_e;
endpackage

// File: rtl/l1d_tag_store.sv
module l1d_tag_store #(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int TAG_W = 21,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0]  lk_hit,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [TAG_W-1:0] inv_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [WAYS-1:0]  fill_way,
    input  logic [TAG_W-1:0] fill_tag
);
    logic [WAYS-1:0] valid_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign lk_hit[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) valid_q[s][w] <= 1'b0;
            end else begin
                // clear first: a same-cycle fill of another line into this way wins
                if (inv_en && valid_q[inv_idx][w] && tag_q[inv_idx][w] == inv_tag)
                    valid_q[inv_idx][w] <= 1'b0;
                if (fill_en && fill_way[w])
                    valid_q[fill_idx][w] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && fill_way[w]) tag_q[fill_idx][w] <= fill_tag;
        end

        // R9: after an invalidate no way holds that line
        assert_inv_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            inv_en |=> !(valid_q[$past(inv_idx)][w] && tag_q[$past(inv_idx)][w] == $past(inv_tag)));
    end

    // R4: a line is never resident in two ways
    assert_single_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit));
endmodule

// File: rtl/l1d_line_store.sv
module l1d_line_store #(
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 16,
    parameter int IDX_W      = 7,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic [IDX_W-1:0]      rd_idx,
    input  logic [WAYS-1:0]       rd_way,
    output logic [LINE_W-1:0]     rd_line,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [WAYS-1:0]       wr_way,
    input  logic [LINE_BYTES-1:0] wr_be,
    input  logic [LINE_W-1:0]     wr_line
);
    logic [LINE_W-1:0] data_q [SETS][WAYS];

    always_comb begin
        rd_line = '0;
        for (int w = 0; w < WAYS; w++)
            if (rd_way[w]) rd_line = rd_line | data_q[rd_idx][w];
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        always_ff @(posedge clk) begin
            if (wr_en && wr_way[w])
                for (int b = 0; b < LINE_BYTES; b++)
                    if (wr_be[b]) data_q[wr_idx][w][b*8 +: 8] <= wr_line[b*8 +: 8];
        end
    end
endmodule

// File: rtl/l1d_rr_victim.sv
module l1d_rr_victim #(
    parameter int SETS   = 128,
    parameter int WAYS   = 4,
    parameter int IDX_W  = 7,
    localparam int PTR_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             advance,
    output logic [WAYS-1:0]  victim
);
    logic [PTR_W-1:0] ptr_q [SETS];

    assign victim = WAYS'(1) << ptr_q[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (advance) begin
            ptr_q[idx] <= (ptr_q[idx] == PTR_W'(WAYS - 1)) ? '0 : ptr_q[idx] + 1'b1;
        end
    end
endmodule

// File: rtl/l1d_wt_cache.sv
module l1d_wt_cache #(
    parameter int ADDR_W     = 32,
    parameter int CAP_BYTES  = 8192,
    parameter int LINE_BYTES = 16,
    parameter int WAYS       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [31:0]             req_wdata,
    input  logic [3:0]              req_be,
    output logic                    rsp_valid,
    output logic [31:0]             rsp_rdata,
    output logic                    l2_req_valid,
    input  logic                    l2_req_ready,
    output logic                    l2_req_write,
    output logic [ADDR_W-1:0]       l2_req_addr,
    output logic [31:0]             l2_req_wdata,
    output logic [3:0]              l2_req_be,
    input  logic                    l2_fill_valid,
    input  logic [LINE_BYTES*8-1:0] l2_fill_data,
    input  logic                    inv_valid,
    input  logic [ADDR_W-1:0]       inv_addr
);
    import l1d_pkg::*;

    localparam int SETS   = CAP_BYTES / (LINE_BYTES * WAYS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LA_W   = ADDR_W - OFF_W;
    localparam int WSEL_W = OFF_W - 2;
    localparam int LINE_W = LINE_BYTES * 8;

    typedef struct packed {
        l1d_state_e        state;
        logic [LA_W-1:0]   pend_line;
        logic [WSEL_W-1:0] pend_word;
        logic              kill;
        logic              rsp_valid;
        logic [31:0]       rsp_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LA_W-1:0]       req_line, inv_line;
    logic [WSEL_W-1:0]     req_word;
    logic [WAYS-1:0]       hit_vec, victim;
    logic                  hit_any, idle, accept, fill_fire, inv_pend, install;
    logic [LINE_W-1:0]     rd_line;
    logic                  dw_en;
    logic [IDX_W-1:0]      dw_idx;
    logic [WAYS-1:0]       dw_way;
    logic [LINE_BYTES-1:0] dw_be;
    logic [LINE_W-1:0]     dw_line;

    assign req_line  = req_addr[ADDR_W-1:OFF_W];
    assign inv_line  = inv_addr[ADDR_W-1:OFF_W];
    assign req_word  = req_addr[OFF_W-1:2];
    assign hit_any   = |hit_vec;
    assign idle      = (ctl_q.state == L1D_IDLE);
    assign req_ready = idle && l2_req_ready;
    assign accept    = req_valid && req_ready;
    assign fill_fire = !idle && l2_fill_valid;
    assign inv_pend  = inv_valid && !idle && (inv_line == ctl_q.pend_line);
    assign install   = fill_fire && !ctl_q.kill && !inv_pend;

    assign l2_req_valid = req_valid && idle && (req_write || !hit_any);
    assign l2_req_write = req_write;
    assign l2_req_addr  = req_write ? {req_addr[ADDR_W-1:2], 2'b00} : {req_line, {OFF_W{1'b0}}};
    assign l2_req_wdata = req_wdata;
    assign l2_req_be    = req_be;
    assign rsp_valid    = ctl_q.rsp_valid;
    assign rsp_rdata    = ctl_q.rsp_data;

    l1d_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) i_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (req_addr[OFF_W +: IDX_W]),
        .lk_tag   (req_addr[ADDR_W-1 -: TAG_W]),
        .lk_hit   (hit_vec),
        .inv_en   (inv_valid),
        .inv_idx  (inv_addr[OFF_W +: IDX_W]),
        .inv_tag  (inv_addr[ADDR_W-1 -: TAG_W]),
        .fill_en  (install),
        .fill_idx (ctl_q.pend_line[IDX_W-1:0]),
        .fill_way (victim),
        .fill_tag (ctl_q.pend_line[LA_W-1 -: TAG_W])
    );

    l1d_rr_victim #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W)) i_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (ctl_q.pend_line[IDX_W-1:0]),
        .advance (install),
        .victim  (victim)
    );

    l1d_line_store #(.SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)) i_data (
        .clk     (clk),
        .rd_idx  (req_addr[OFF_W +: IDX_W]),
        .rd_way  (hit_vec),
        .rd_line (rd_line),
        .wr_en   (dw_en),
        .wr_idx  (dw_idx),
        .wr_way  (dw_way),
        .wr_be   (dw_be),
        .wr_line (dw_line)
    );

    // data write port: store-hit merge in IDLE, line install in FILL
    always_comb begin
        dw_en   = install;
        dw_idx  = ctl_q.pend_line[IDX_W-1:0];
        dw_way  = victim;
        dw_be   = '1;
        dw_line = l2_fill_data;
        if (idle) begin
            dw_en   = accept && req_write && hit_any;
            dw_idx  = req_addr[OFF_W +: IDX_W];
            dw_way  = hit_vec;
            dw_be   = LINE_BYTES'(req_be) << (req_word * 4);
            dw_line = {(LINE_BYTES / 4){req_wdata}};
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        if (idle) begin
            if (accept && !req_write) begin
                if (hit_any) begin
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_data  = rd_line[req_word*32 +: 32];
                end else begin
                    ctl_d.state     = L1D_FILL;
                    ctl_d.pend_line = req_line;
                    ctl_d.pend_word = req_word;
                    ctl_d.kill      = inv_valid && (inv_line == req_line);
                end
            end
        end else begin
            if (inv_pend) ctl_d.kill = 1'b1;
            if (l2_fill_valid) begin
                ctl_d.state     = L1D_IDLE;
                ctl_d.kill      = 1'b0;
                ctl_d.rsp_valid = 1'b1;
                ctl_d.rsp_data  = l2_fill_data[ctl_q.pend_word*32 +: 32];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assert_store_forwarded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write) |-> (l2_req_valid && l2_req_write && l2_req_be == req_be));
    assert_no_allocate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write) |=> (ctl_q.state == L1D_IDLE && !rsp_valid));
    assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == L1D_FILL) |-> !req_ready);
    assert_fill_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_fire |=> (rsp_valid && ctl_q.state == L1D_IDLE));
    assert_hit_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write && hit_any) |=> rsp_valid);
    assert_l2_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !l2_req_ready |-> !req_ready);
endmodule

// File: tb/test_l1d_wt_cache.sv
module test_l1d_wt_cache;
    localparam int AW = 16, CAP = 256, LB = 16, WY = 2;
    localparam int SETS = CAP / (LB * WY);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, l2_req_ready = 1, l2_fill_valid = 0, inv_valid = 0;
    logic [AW-1:0] req_addr = '0, inv_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0] req_be = '0;
    logic [LB*8-1:0] l2_fill_data = '0;
    logic req_ready, rsp_valid, l2_req_valid, l2_req_write;
    logic [31:0] rsp_rdata, l2_req_wdata;
    logic [AW-1:0] l2_req_addr;
    logic [3:0] l2_req_be;

    always #10 clk = ~clk;

    l1d_wt_cache #(.ADDR_W(AW), .CAP_BYTES(CAP), .LINE_BYTES(LB), .WAYS(WY)) i_l1d_wt_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .l2_req_valid(l2_req_valid),
        .l2_req_ready(l2_req_ready), .l2_req_write(l2_req_write), .l2_req_addr(l2_req_addr),
        .l2_req_wdata(l2_req_wdata), .l2_req_be(l2_req_be), .l2_fill_valid(l2_fill_valid),
        .l2_fill_data(l2_fill_data), .inv_valid(inv_valid), .inv_addr(inv_addr));

    int checks = 0, fails = 0;
    logic [31:0] mem [256];
    bit mv [SETS][WY];
    int mt [SETS][WY];
    int mrr [SETS];

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic int set_of(int a); return (a / LB) % SETS; endfunction
    function automatic int tag_of(int a); return a / (LB * SETS); endfunction
    function automatic bit mhit(int a);
        for (int w = 0; w < WY; w++)
            if (mv[set_of(a)][w] && mt[set_of(a)][w] == tag_of(a)) return 1'b1;
        return 1'b0;
    endfunction
    function automatic logic [LB*8-1:0] line_of(int a);
        logic [LB*8-1:0] l;
        for (int k = 0; k < LB / 4; k++) l[32*k +: 32] = mem[((a & ~(LB-1)) >> 2) + k];
        return l;
    endfunction
    function automatic void m_inv(int a);
        for (int w = 0; w < WY; w++)
            if (mv[set_of(a)][w] && mt[set_of(a)][w] == tag_of(a)) mv[set_of(a)][w] = 1'b0;
    endfunction

    task automatic do_load(input int a, input bit race, input string tg);
        bit h, kill;
        int n;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = AW'(a); req_be = '0;
        #1;
        h = mhit(a);
        chk(req_ready === 1'b1, "R11", req_ready, 1);
        chk(l2_req_valid === !h, tg, l2_req_valid, !h);
        if (!h) chk(l2_req_addr === AW'(a & ~(LB-1)) && l2_req_write === 1'b0, "R3", l2_req_addr, a & ~(LB-1));
        @(negedge clk);
        req_valid = 0;
        #1;
        if (h) begin
            chk(rsp_valid === 1'b1 && rsp_rdata === mem[a>>2], tg, rsp_rdata, mem[a>>2]);
        end else begin
            kill = 0;
            n = $urandom_range(0, 3);
            chk(req_ready === 1'b0, "R11", req_ready, 0);
            for (int i = 0; i < n; i++) begin
                if (race && i == n - 1) begin
                    inv_valid = 1; inv_addr = AW'(a); mem[a>>2] = $urandom; kill = 1;
                end
                @(negedge clk);
                inv_valid = 0;
                #1;
                chk(req_ready === 1'b0 && rsp_valid === 1'b0, "R11", {req_ready, rsp_valid}, 0);
            end
            if (race && !kill) begin
                inv_valid = 1; inv_addr = AW'(a); mem[a>>2] = $urandom; kill = 1;
            end
            l2_fill_valid = 1; l2_fill_data = line_of(a);
            @(negedge clk);
            l2_fill_valid = 0; inv_valid = 0;
            #1;
            chk(rsp_valid === 1'b1 && rsp_rdata === mem[a>>2], race ? "R10" : "R3", rsp_rdata, mem[a>>2]);
            if (!kill) begin
                mv[set_of(a)][mrr[set_of(a)]] = 1'b1;
                mt[set_of(a)][mrr[set_of(a)]] = tag_of(a);
                mrr[set_of(a)] = (mrr[set_of(a)] + 1) % WY;
            end
        end
    endtask

    task automatic do_store(input int a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d; req_be = be;
        #1;
        chk(req_ready === 1'b1 && l2_req_valid === 1'b1 && l2_req_write === 1'b1 &&
            l2_req_addr === AW'(a) && l2_req_wdata === d && l2_req_be === be, "R5", l2_req_addr, a);
        @(negedge clk);
        req_valid = 0; req_write = 0;
        #1;
        chk(rsp_valid === 1'b0, "R5", rsp_valid, 0);
        for (int b = 0; b < 4; b++) if (be[b]) mem[a>>2][b*8 +: 8] = d[b*8 +: 8];
    endtask

    task automatic do_remote(input int a);
        @(negedge clk);
        inv_valid = 1; inv_addr = AW'(a); mem[a>>2] = $urandom;
        m_inv(a);
        @(negedge clk);
        inv_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        for (int s = 0; s < SETS; s++) begin
            mrr[s] = 0;
            for (int w = 0; w < WY; w++) begin mv[s][w] = 0; mt[s][w] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && l2_req_valid === 1'b0, "R11",
            {req_ready, rsp_valid, l2_req_valid}, 3'b100);

        // R3 miss then R4 hit on the same line, other word
        do_load(32'h040, 0, "R3");
        do_load(32'h048, 0, "R4");
        // R6 store hit merges bytes
        do_store(32'h048, 32'hA5C3_1E2F, 4'b0101);
        do_load(32'h048, 0, "R6");
        // R7 store miss does not allocate
        do_store(32'h210, 32'h1234_5678, 4'b1111);
        do_load(32'h210, 0, "R7");
        // R8/R1: three lines 128 bytes apart share set 1
        do_load(32'h090, 0, "R8");
        do_load(32'h110, 0, "R8");
        do_load(32'h190, 0, "R8");
        do_load(32'h110, 0, "R1");
        do_load(32'h090, 0, "R8");
        // R9 invalidate a resident line
        do_load(32'h300, 0, "R3");
        do_remote(32'h304);
        do_load(32'h300, 0, "R9");
        // R10 race with outstanding fill, then line must still miss
        do_load(32'h3C4, 1, "R10");
        do_load(32'h3C4, 0, "R10");
        // R12 second level not ready
        @(negedge clk);
        l2_req_ready = 0; req_valid = 1; req_write = 0; req_addr = AW'(32'h300);
        #1;
        chk(req_ready === 1'b0, "R12", req_ready, 0);
        @(negedge clk);
        req_valid = 0;
        #1;
        chk(rsp_valid === 1'b0, "R12", rsp_valid, 0);
        l2_req_ready = 1;

        for (int i = 0; i < 400; i++) begin
            int op, a;
            op = $urandom_range(0, 9);
            a = $urandom_range(0, 255) * 4;
            if (op <= 4) do_load(a, 0, "R2");
            else if (op <= 7) do_store(a, $urandom, 4'($urandom_range(1, 15)));
            else if (op == 8) do_remote(a);
            else do_load(a, 1, "R10");
        end
        finish_run();
    end
endmodule